// File: doc/BRIEF.md
# Spread-Spectrum Triangle Offset Generator

This block drives the fractional part of a PLL feedback divider so that the synthesized clock is slowly swept in frequency. Its energy is spread over a band instead of sitting in one narrow line. The block runs on the reference clock. Once per reference cycle it emits a signed offset word, scaled in units of 1/65536 of the nominal divide ratio, together with a flag that marks the word as live. The offset follows a linear triangle whose period is a fixed 512 reference cycles. The modulation rate is therefore the reference frequency divided by 512.

Two select inputs choose the profile. One picks between down spread and center spread. Down spread only ever lowers the frequency. Center spread swings evenly above and below nominal. The other select picks the narrower or the wider setting of the chosen mode. The selects are sampled only when a period starts, so a change never causes a step in frequency partway through a sweep. An active-low power-down stops modulation. When it is released, the sweep starts again from its beginning.

A second output carries the offset for the unmodulated reference path. That offset is always zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: The offset sequence repeats every 512 cycles. The first live cycle after reset release or power-down release is profile step n=0, and step n=0 follows step n=511.
- R2: When mode_sel=0 (down spread), the offset is 0 at step 0 and at its most negative at step 256. That peak is -1638 when range_sel=0 and -2294 when range_sel=1. The offset is never positive in this mode.
- R3: When mode_sel=1 (center spread), the offset is +H at step 0 and -H at step 256. H is 409 when range_sel=0 and 573 when range_sel=1.
- R4: The offset follows a linear triangle. Let D be the total deviation: 1638, 2294, 818 or 1146, in the mode and range order of R2 and R3. Let t = n for n<=256 and t = 512-n otherwise. The offset equals floor((S - D*t)/256), where S is 0 for down spread and D*128 for center spread. Between steps, an internal accumulator moves by exactly D.
- R5: A change on mode_sel or range_sel during a period has no effect until the next step 0. It takes effect at that step.
- R6: While pwr_dn_n is low, mod_valid is 0 and mod_offset is 0 from the next cycle onward. After release, the first live cycle is step 0 of the currently selected profile.
- R7: ref_offset is zero in every cycle, whatever the selects, power-down and reset inputs do.
- R8: The reset is synchronous and active high. While it is asserted, mod_valid and mod_offset are 0. The first live cycle follows the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 1 | 0 selects the narrower deviation, 1 the wider |
| mode_sel | input | 1 | 0 selects down spread, 1 center spread |
| pwr_dn_n | input | 1 | Active-low power-down |
| mod_offset | output | 16 | Signed divider offset, units of 1/65536 |
| mod_valid | output | 1 | Modulated offset is live |
| ref_offset | output | 16 | Offset for the unmodulated path, always zero |

## Verification
A wrong phase count shows up at the ports within one period. Either the peak lands on a step other than 256, or the return to the start value lands on a step other than 512. A wrong increment shows up at the first sampled step after step 0, because every live cycle is compared against the closed-form triangle. A select register that is loaded at the wrong moment makes the profile bend in the same cycle the select input changes. A restart from the wrong state after power-down is seen in the first live cycle after release.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic {
        SPREAD_DOWN   = 1'b0,
        SPREAD_CENTER = 1'b1
    } spread_mode_e;

    typedef struct packed {
        spread_mode_e mode;
        logic         wide;
    } spread_cfg_t;

    // Total deviation for a configuration, in 1/65536 units of the divide ratio.
    function automatic int pick_dev(spread_cfg_t c, int dn_lo, int dn_hi, int ct_lo, int ct_hi);
        if (c.mode == SPREAD_CENTER)
            return c.wide ? ct_hi : ct_lo;
        else
            return c.wide ? dn_hi : dn_lo;
    endfunction

endpackage

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr #(
    parameter int PH_W = 9
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    output logic            run,
    output logic [PH_W-1:0] phase,
    output logic            load
);
    localparam logic [PH_W-1:0] LAST = {PH_W{1'b1}};

    // Load a fresh profile start on the first live cycle and on every wrap.
    assign load = en && (!run || phase == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run   <= 1'b0;
            phase <= '0;
        end else begin
            run   <= 1'b1;
            phase <= run ? phase + 1'b1 : '0;
        end
    end

    // R1: the step after the last one is step 0
    a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (en && run && phase == LAST) |=> (phase == '0));

    // R6: a first live cycle always starts at step 0
    a_r6_restart_step0: assert property (@(posedge clk) disable iff (rst)
        (en && !run) |=> (run && phase == '0));

endmodule

// File: rtl/ssc_cfg_hold.sv
module ssc_cfg_hold
    import ssc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  spread_cfg_t cfg_in,
    output spread_cfg_t cfg_q,
    output spread_cfg_t cfg_eff
);
    // The configuration used this cycle: the fresh inputs on a load, otherwise the held one.
    assign cfg_eff = load ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '{mode: SPREAD_CENTER, wide: 1'b1};
        else if (load)
            cfg_q <= cfg_in;
    end

    // R5: the held selection moves only at a profile boundary
    a_r5_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/ssc_ramp_acc.sv
module ssc_ramp_acc #(
    parameter int PH_W  = 9,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    run,
    input  logic                    load,
    input  logic [PH_W-1:0]         phase,
    input  logic signed [ACC_W-1:0] step,
    input  logic signed [ACC_W-1:0] start,
    output logic signed [ACC_W-1:0] acc
);
    // The top bit of the phase tells the falling half (0) from the rising half (1).
    logic rising;
    assign rising = phase[PH_W-1];

    always_ff @(posedge clk) begin
        if (rst || !en)
            acc <= '0;
        else if (load)
            acc <= start;
        else if (run)
            acc <= rising ? acc + step : acc - step;
    end

    // R4: between loads the accumulator moves by exactly one step
    a_r4_constant_step: assert property (@(posedge clk) disable iff (rst)
        (en && run && !load) |=>
            ((acc - $past(acc) == $past(step)) || ($past(acc) - acc == $past(step))));

    // R1: each period begins from the configured start value
    a_r1_period_start: assert property (@(posedge clk) disable iff (rst)
        (en && load) |=> (acc == $past(start)));

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int PH_W      = 9,
    parameter int OFS_W     = 16,
    parameter int DEV_DN_LO = 1638,
    parameter int DEV_DN_HI = 2294,
    parameter int DEV_CT_LO = 818,
    parameter int DEV_CT_HI = 1146
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    range_sel,
    input  logic                    mode_sel,
    input  logic                    pwr_dn_n,
    output logic signed [OFS_W-1:0] mod_offset,
    output logic                    mod_valid,
    output logic signed [OFS_W-1:0] ref_offset
);
    localparam int GUARD = PH_W - 1;
    localparam int ACC_W = OFS_W + GUARD;

    logic                    run;
    logic                    load;
    logic [PH_W-1:0]         phase;
    spread_cfg_t             cfg_in;
    spread_cfg_t             cfg_q;
    spread_cfg_t             cfg_eff;
    logic signed [ACC_W-1:0] step;
    logic signed [ACC_W-1:0] start;
    logic signed [ACC_W-1:0] acc;

    assign cfg_in = '{mode: spread_mode_e'(mode_sel), wide: range_sel};

    ssc_phase_ctr #(.PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .en    (pwr_dn_n),
        .run   (run),
        .phase (phase),
        .load  (load)
    );

    ssc_cfg_hold u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .cfg_eff (cfg_eff)
    );

    // In accumulator units one output LSB is 2**GUARD, so the step equals the total deviation.
    // Center spread starts half a sweep above nominal.
    always_comb begin
        step  = ACC_W'(pick_dev(cfg_eff, DEV_DN_LO, DEV_DN_HI, DEV_CT_LO, DEV_CT_HI));
        start = (cfg_eff.mode == SPREAD_CENTER) ? (step <<< (GUARD - 1)) : '0;
    end

    ssc_ramp_acc #(.PH_W(PH_W), .ACC_W(ACC_W)) u_ramp (
        .clk   (clk),
        .rst   (rst),
        .en    (pwr_dn_n),
        .run   (run),
        .load  (load),
        .phase (phase),
        .step  (step),
        .start (start),
        .acc   (acc)
    );

    // Dropping the guard bits floors toward minus infinity.
    assign mod_offset = acc[ACC_W-1:GUARD];
    assign mod_valid  = run;
    assign ref_offset = '0;

    // R2: down spread never raises the frequency
    a_r2_down_not_positive: assert property (@(posedge clk) disable iff (rst)
        (mod_valid && cfg_q.mode == SPREAD_DOWN) |-> ($signed(mod_offset) <= 0));

    // R3: center spread stays within half the total deviation
    a_r3_center_bounded: assert property (@(posedge clk) disable iff (rst)
        (mod_valid && cfg_q.mode == SPREAD_CENTER) |->
            (($signed(mod_offset) <= pick_dev(cfg_q, DEV_DN_LO, DEV_DN_HI, DEV_CT_LO, DEV_CT_HI) / 2) &&
             ($signed(mod_offset) >= -(pick_dev(cfg_q, DEV_DN_LO, DEV_DN_HI, DEV_CT_LO, DEV_CT_HI) / 2))));

    // R6: power-down silences the modulated output on the next cycle
    a_r6_power_down_quiet: assert property (@(posedge clk) disable iff (rst)
        (!pwr_dn_n) |=> (!mod_valid && mod_offset == '0));

endmodule

// File: tb/test_ssc_profile_gen.sv
module test_ssc_profile_gen;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               range_sel = 1'b0;
    logic               mode_sel = 1'b0;
    logic               pwr_dn_n = 1'b1;
    logic signed [15:0] mod_offset;
    logic               mod_valid;
    logic signed [15:0] ref_offset;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    ssc_profile_gen i_ssc_profile_gen (
        .clk        (clk),
        .rst        (rst),
        .range_sel  (range_sel),
        .mode_sel   (mode_sel),
        .pwr_dn_n   (pwr_dn_n),
        .mod_offset (mod_offset),
        .mod_valid  (mod_valid),
        .ref_offset (ref_offset)
    );

    // Each row: mode, range, expected value at step 0, expected value at step 256.
    typedef struct packed {
        bit     mode;
        bit     range;
        integer at0;
        integer at256;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{1'b0, 1'b0, 0,    -1638},
        '{1'b0, 1'b1, 0,    -2294},
        '{1'b1, 1'b0, 409,  -409},
        '{1'b1, 1'b1, 573,  -573}
    };

    // Closed-form triangle from R4.
    function automatic int model(bit m, bit r, int n);
        int d, t, v;
        d = m ? (r ? 1146 : 818) : (r ? 2294 : 1638);
        t = (n % 512 <= 256) ? (n % 512) : (512 - n % 512);
        v = (m ? d * 128 : 0) - d * t;
        if (v >= 0) return v / 256;
        return -((-v + 255) / 256);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample half a period after the rising edge.
    task automatic step_sample();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_run(bit m, bit r);
        @(negedge clk);
        rst = 1'b1; pwr_dn_n = 1'b1; mode_sel = m; range_sel = r;
        step_sample();
        step_sample();
        // R8: reset state
        check(mod_valid == 1'b0, "R8 valid in reset", int'(mod_valid), 0);
        check(mod_offset == 0, "R8 offset in reset", int'(mod_offset), 0);
        check(ref_offset == 0, "R7 ref in reset", int'(ref_offset), 0);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // Table walk: two full periods per configuration.
        foreach (ROWS[i]) begin
            start_run(ROWS[i].mode, ROWS[i].range);
            for (int n = 0; n < 1030; n++) begin
                step_sample();
                check(mod_valid == 1'b1, "R1 valid while running", int'(mod_valid), 1);
                check(int'(mod_offset) == model(ROWS[i].mode, ROWS[i].range, n),
                      "R4 triangle value", int'(mod_offset), model(ROWS[i].mode, ROWS[i].range, n));
                if (n % 512 == 0)
                    check(int'(mod_offset) == ROWS[i].at0, ROWS[i].mode ? "R3 center start" : "R2 down start",
                          int'(mod_offset), ROWS[i].at0);
                if (n % 512 == 256)
                    check(int'(mod_offset) == ROWS[i].at256, ROWS[i].mode ? "R3 center trough" : "R2 down peak",
                          int'(mod_offset), ROWS[i].at256);
                if (!ROWS[i].mode)
                    check(int'(mod_offset) <= 0, "R2 never positive", int'(mod_offset), 0);
                if (n % 97 == 0)
                    check(ref_offset == 0, "R7 ref stays zero", int'(ref_offset), 0);
            end
        end

        // R5: a select change at step 100 waits for the next boundary.
        start_run(1'b0, 1'b0);
        for (int n = 0; n < 800; n++) begin
            step_sample();
            if (n <= 511)
                check(int'(mod_offset) == model(1'b0, 1'b0, n), "R5 old profile kept",
                      int'(mod_offset), model(1'b0, 1'b0, n));
            else
                check(int'(mod_offset) == model(1'b1, 1'b1, n - 512), "R5 new profile at boundary",
                      int'(mod_offset), model(1'b1, 1'b1, n - 512));
            if (n == 100) begin
                mode_sel = 1'b1;
                range_sel = 1'b1;
            end
        end

        // R6: power-down mid-period, then release.
        pwr_dn_n = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step_sample();
            check(mod_valid == 1'b0, "R6 valid low in power-down", int'(mod_valid), 0);
            check(mod_offset == 0, "R6 offset zero in power-down", int'(mod_offset), 0);
            check(ref_offset == 0, "R7 ref in power-down", int'(ref_offset), 0);
        end
        mode_sel = 1'b0;
        range_sel = 1'b1;
        pwr_dn_n = 1'b1;
        for (int n = 0; n < 260; n++) begin
            step_sample();
            check(mod_valid == 1'b1, "R6 valid after release", int'(mod_valid), 1);
            check(int'(mod_offset) == model(1'b0, 1'b1, n), "R6 restart from step 0",
                  int'(mod_offset), model(1'b0, 1'b1, n));
        end

        // R8: reset asserted mid-run clears the outputs on the next edge.
        rst = 1'b1;
        step_sample();
        check(mod_valid == 1'b0, "R8 valid after mid-run reset", int'(mod_valid), 0);
        check(mod_offset == 0, "R8 offset after mid-run reset", int'(mod_offset), 0);
        rst = 1'b0;
        step_sample();
        check(mod_valid == 1'b1, "R8 first live cycle after release", int'(mod_valid), 1);
        check(int'(mod_offset) == model(1'b0, 1'b1, 0), "R1 step 0 after reset release",
              int'(mod_offset), model(1'b0, 1'b1, 0));
        step_sample();
        check(int'(mod_offset) == model(1'b0, 1'b1, 1), "R4 first step after release",
              int'(mod_offset), model(1'b0, 1'b1, 1));

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule